// File: doc/BRIEF.md
# Power-Management Event Enable Logic

This block holds the 16-bit enable word that decides which general-purpose power-management status sources may wake the system or raise a system-control interrupt (SCI). Firmware reaches the word through an I/O-style port: an address compare, read and write strobes, and 16-bit data. The block ANDs each incoming status flag with its enable, ORs the results into a registered wake request and a registered SCI request, and watches a thermal pin whose active level can be programmed.

The enable bits sit in separate reset groups. Bits 0 to 7 follow the core reset. The PME enable also survives core reset, but the resume reset clears it. The ring-indicate enable is cleared only by the RTC reset. A power-button-override clear wipes every bit. The sleep state and a flag that says whether soft-off was entered by override come from outside the block. PME wake from soft-off is allowed only when that flag is low.

Top module: `pme_event_enable`

## Requirements
- R1: After reset, a read at the block address (`io_rd` high, `io_addr` equal to `BASE_ADDR`) returns 0000h. Whenever the read is not addressed, `io_rdata` is 0000h.
- R2: Bits 15:12, 10, 9, 7 and 1 (mask F682h) always read as zero. Writing ones to them has no effect.
- R3: A write at the block address stores the implemented bits (mask 097Dh), and they read back unchanged. Bit 0 is the thermal enable, bit 2 the thermal polarity, bit 3 USB1, bit 4 USB2, bit 5 audio codec, bit 6 TCO SCI, bit 8 ring indicate and bit 11 PME.
- R4: A cycle with `pbo_clr` high clears every bit, including bits 8 and 11.
- R5: Asserting `core_rst_n` clears bits 0 to 7 and leaves bits 8 and 11 unchanged.
- R6: Asserting `rsm_rst_n` clears bits 0 to 7 and bit 11 and leaves bit 8 unchanged.
- R7: Asserting `rtc_rst_n` clears every bit.
- R8: One clock after the inputs change, `wake_req` is high if the status and enable bits are both set for any of the following pairs: USB1 (bit 3), USB2 (bit 4), audio (bit 5) or ring indicate (bit 8).
- R9: PME status with bit 11 set adds to `wake_req` only when `sleep_state` is 1 to 4, or when it is 5 with `s5_by_override` low. In S0 and in override-entered S5 it does not.
- R10: One clock after the inputs change, `sci_req` is high if PME status is set with bit 11 set, or if TCO status is set with bit 6 set. This holds in any sleep state.
- R11: `thrm_pin` passes through two flip-flops. When bit 0 is set, the pin level selected by bit 2 (0 = low, 1 = high) is the active level. The rising edge of "enabled and active" gives a `thrm_set` pulse exactly one cycle long, two clocks after the pin change. There is no pulse while bit 0 is clear.
- R12: When `pbo_clr` and an addressed write occur in the same cycle, the clear wins and the word reads 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Core-domain reset, active low, asynchronous |
| rsm_rst_n | input | 1 | Resume-domain reset, active low, asynchronous |
| rtc_rst_n | input | 1 | RTC-domain reset, active low, asynchronous |
| pbo_clr | input | 1 | Power-button-override clear of all enables |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, zero when not addressed |
| st_pme | input | 1 | PME status |
| st_ri | input | 1 | Ring-indicate status |
| st_tco | input | 1 | TCO SCI status |
| st_audio | input | 1 | Audio codec status |
| st_usb2 | input | 1 | USB controller 2 status |
| st_usb1 | input | 1 | USB controller 1 status |
| thrm_pin | input | 1 | Asynchronous thermal pin |
| sleep_state | input | 3 | Current sleep state, 0 = S0 up to 5 = S5 |
| s5_by_override | input | 1 | Soft-off was entered by power-button override |
| wake_req | output | 1 | Registered wake request |
| sci_req | output | 1 | Registered SCI request |
| thrm_set | output | 1 | One-cycle thermal status set pulse |

## Verification
Two pairs of functions can land in the same cycle. In the first, the bench drives the override clear and an addressed write of FFFFh on the same edge, and then reads back zero. In the second, the bench makes the thermal pin active and, in the cycle the synchronized level arrives, clears the thermal enable with a write. It then checks that no set pulse appears and that the pulse does appear when the order is reversed. The reset-domain checks apply one reset at a time after a full write and compare the surviving bits against what each domain is meant to keep.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int unsigned WORD_W = 16;

  localparam int unsigned B_THRM_EN  = 0;
  localparam int unsigned B_THRM_POL = 2;
  localparam int unsigned B_USB1     = 3;
  localparam int unsigned B_USB2     = 4;
  localparam int unsigned B_AUDIO    = 5;
  localparam int unsigned B_TCO      = 6;
  localparam int unsigned B_RI       = 8;
  localparam int unsigned B_PME      = 11;

  localparam logic [WORD_W-1:0] IMPL_MASK =
    (16'h1 << B_THRM_EN) | (16'h1 << B_THRM_POL) | (16'h1 << B_USB1) |
    (16'h1 << B_USB2) | (16'h1 << B_AUDIO) | (16'h1 << B_TCO) |
    (16'h1 << B_RI) | (16'h1 << B_PME);

  localparam int unsigned N_DOM = 3;
  typedef enum logic [1:0] {DOM_CORE = 2'd0, DOM_PME = 2'd1, DOM_RI = 2'd2} dom_e;

  typedef struct packed {
    logic pme;
    logic ri;
    logic tco;
    logic audio;
    logic usb2;
    logic usb1;
  } src_t;
endpackage

// File: rtl/pme_rst_sync.sv
module pme_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pme_en_reg.sv
module pme_en_reg
  import pme_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE_ADDR = 16'h0040
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              pme_rst_n,
  input  logic              ri_rst_n,
  input  logic              pbo_clr,
  input  logic [WORD_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [WORD_W-1:0] io_wdata,
  output logic [WORD_W-1:0] io_rdata,
  output logic [WORD_W-1:0] en_word
);
  localparam logic [7:0] CORE_MASK = IMPL_MASK[7:0];

  logic       hit;
  logic       wr_en;
  logic [7:0] core_q, core_d;
  logic       pme_q, pme_d;
  logic       ri_q, ri_d;
  logic       core_ce, pme_ce, ri_ce;

  assign hit   = (io_addr == BASE_ADDR);
  assign wr_en = hit && io_wr;

  always_comb begin
    core_ce = pbo_clr || wr_en;
    pme_ce  = core_ce;
    ri_ce   = core_ce;
    core_d  = pbo_clr ? 8'h00 : (io_wdata[7:0] & CORE_MASK);
    pme_d   = pbo_clr ? 1'b0  : io_wdata[B_PME];
    ri_d    = pbo_clr ? 1'b0  : io_wdata[B_RI];
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  core_q <= '0;
    else if (core_ce) core_q <= core_d;
  end

  always_ff @(posedge clk or negedge pme_rst_n) begin
    if (!pme_rst_n)  pme_q <= 1'b0;
    else if (pme_ce) pme_q <= pme_d;
  end

  always_ff @(posedge clk or negedge ri_rst_n) begin
    if (!ri_rst_n)  ri_q <= 1'b0;
    else if (ri_ce) ri_q <= ri_d;
  end

  always_comb begin
    en_word         = '0;
    en_word[7:0]    = core_q;
    en_word[B_RI]   = ri_q;
    en_word[B_PME]  = pme_q;
  end

  assign io_rdata = (hit && io_rd) ? en_word : '0;

  assert_pbo_wins_R12: assert property (@(posedge clk) disable iff (!core_rst_n)
    pbo_clr |=> (en_word == '0));

  assert_write_store_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && !pbo_clr) |=> (en_word == ($past(io_wdata) & IMPL_MASK)));

  always_comb begin
    assert_reserved_zero_R2: assert ((io_rdata & ~IMPL_MASK) == '0);
  end
endmodule

// File: rtl/pme_thrm_detect.sv
module pme_thrm_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic enable,
  input  logic polarity,
  output logic set_pulse
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic pin_s;
  logic cond, cond_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cond_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cond_q <= cond;
    end
  end

  assign pin_s     = sync_q[SYNC_STAGES-1];
  assign cond      = enable && (polarity ? pin_s : !pin_s);
  assign set_pulse = cond && !cond_q;

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> !set_pulse);

  assert_pulse_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> enable);
endmodule

// File: rtl/pme_req_combine.sv
module pme_req_combine
  import pme_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] en_word,
  input  src_t              src,
  input  logic [2:0]        sleep_state,
  input  logic              s5_by_override,
  output logic              wake_req,
  output logic              sci_req
);
  logic pme_hit, pme_wake_ok;
  logic wake_d, sci_d;
  logic wake_q, sci_q;

  always_comb begin
    pme_hit     = src.pme && en_word[B_PME];
    pme_wake_ok = ((sleep_state >= 3'd1) && (sleep_state <= 3'd4)) ||
                  ((sleep_state == 3'd5) && !s5_by_override);
    wake_d = (pme_hit && pme_wake_ok) ||
             (src.ri    && en_word[B_RI])    ||
             (src.audio && en_word[B_AUDIO]) ||
             (src.usb2  && en_word[B_USB2])  ||
             (src.usb1  && en_word[B_USB1]);
    sci_d  = pme_hit || (src.tco && en_word[B_TCO]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      sci_q  <= 1'b0;
    end else begin
      wake_q <= wake_d;
      sci_q  <= sci_d;
    end
  end

  assign wake_req = wake_q;
  assign sci_req  = sci_q;

  assert_override_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sleep_state == 3'd5) && s5_by_override && !src.ri && !src.audio &&
     !src.usb2 && !src.usb1) |=> !wake_req);

  assert_tco_sci_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src.tco && en_word[B_TCO]) |=> sci_req);
endmodule

// File: rtl/pme_event_enable.sv
module pme_event_enable
  import pme_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'h0040,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        core_rst_n,
  input  logic        rsm_rst_n,
  input  logic        rtc_rst_n,
  input  logic        pbo_clr,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  input  logic        st_pme,
  input  logic        st_ri,
  input  logic        st_tco,
  input  logic        st_audio,
  input  logic        st_usb2,
  input  logic        st_usb1,
  input  logic        thrm_pin,
  input  logic [2:0]  sleep_state,
  input  logic        s5_by_override,
  output logic        wake_req,
  output logic        sci_req,
  output logic        thrm_set
);
  logic [N_DOM-1:0]  raw_rst_n;
  logic [N_DOM-1:0]  dom_rst_n;
  logic [WORD_W-1:0] en_word;
  src_t              src;

  always_comb begin
    raw_rst_n[DOM_CORE] = core_rst_n && rsm_rst_n && rtc_rst_n;
    raw_rst_n[DOM_PME]  = rsm_rst_n && rtc_rst_n;
    raw_rst_n[DOM_RI]   = rtc_rst_n;
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_rst
    pme_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (raw_rst_n[d]),
      .srst_n (dom_rst_n[d])
    );
  end

  pme_en_reg #(.BASE_ADDR(BASE_ADDR)) u_reg (
    .clk        (clk),
    .core_rst_n (dom_rst_n[DOM_CORE]),
    .pme_rst_n  (dom_rst_n[DOM_PME]),
    .ri_rst_n   (dom_rst_n[DOM_RI]),
    .pbo_clr    (pbo_clr),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .en_word    (en_word)
  );

  always_comb begin
    src.pme   = st_pme;
    src.ri    = st_ri;
    src.tco   = st_tco;
    src.audio = st_audio;
    src.usb2  = st_usb2;
    src.usb1  = st_usb1;
  end

  pme_req_combine u_req (
    .clk            (clk),
    .rst_n          (dom_rst_n[DOM_CORE]),
    .en_word        (en_word),
    .src            (src),
    .sleep_state    (sleep_state),
    .s5_by_override (s5_by_override),
    .wake_req       (wake_req),
    .sci_req        (sci_req)
  );

  pme_thrm_detect #(.SYNC_STAGES(SYNC_STAGES)) u_thrm (
    .clk       (clk),
    .rst_n     (dom_rst_n[DOM_CORE]),
    .pin       (thrm_pin),
    .enable    (en_word[B_THRM_EN]),
    .polarity  (en_word[B_THRM_POL]),
    .set_pulse (thrm_set)
  );

  assert_ri_kept_core_rst_R5: assert property (@(posedge clk) disable iff (!dom_rst_n[DOM_RI])
    (!dom_rst_n[DOM_CORE] && rsm_rst_n && !pbo_clr && !(io_wr && io_addr == BASE_ADDR))
      |=> $stable(en_word[B_RI]));

  assert_core_cleared_R5: assert property (@(posedge clk)
    !dom_rst_n[DOM_CORE] |-> (en_word[7:0] == 8'h00));
endmodule

// File: tb/pme_event_enable_test.sv
module pme_event_enable_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] ADDR = 16'h0040;

  logic clk = 1'b0;
  logic core_rst_n, rsm_rst_n, rtc_rst_n, pbo_clr;
  logic [15:0] io_addr, io_wdata, io_rdata;
  logic io_wr, io_rd;
  logic st_pme, st_ri, st_tco, st_audio, st_usb2, st_usb1, thrm_pin;
  logic [2:0] sleep_state;
  logic s5_by_override, wake_req, sci_req, thrm_set;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pme_event_enable uut (
    .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n), .rtc_rst_n(rtc_rst_n),
    .pbo_clr(pbo_clr), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .st_pme(st_pme), .st_ri(st_ri),
    .st_tco(st_tco), .st_audio(st_audio), .st_usb2(st_usb2), .st_usb1(st_usb1),
    .thrm_pin(thrm_pin), .sleep_state(sleep_state), .s5_by_override(s5_by_override),
    .wake_req(wake_req), .sci_req(sci_req), .thrm_set(thrm_set)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0;
  endtask

  task automatic rd(output logic [15:0] d);
    @(negedge clk);
    io_addr = ADDR; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0; io_addr = 16'h0;
  endtask

  task automatic clear_status();
    st_pme = 0; st_ri = 0; st_tco = 0; st_audio = 0; st_usb2 = 0; st_usb1 = 0;
  endtask

  task automatic test_reset_state();
    logic [15:0] d;
    rd(d); check("R1 reset value", d, 16'h0000);
    @(negedge clk); io_addr = ADDR + 16'h2; io_rd = 1'b1;
    #1 check("R1 unaddressed read", io_rdata, 16'h0000);
    io_rd = 0; io_addr = 0;
  endtask

  task automatic test_rw();
    logic [15:0] d;
    wr(ADDR, 16'hFFFF); rd(d); check("R2 reserved ignored", d, 16'h097D);
    wr(ADDR, 16'h0000); rd(d); check("R3 write zero", d, 16'h0000);
    wr(ADDR, 16'h0854); rd(d); check("R3 pattern 0854", d, 16'h0854);
    wr(ADDR, 16'h0129); rd(d); check("R3 pattern 0129", d, 16'h0129);
    wr(ADDR + 16'h4, 16'h0000); rd(d); check("R3 other address", d, 16'h0129);
  endtask

  task automatic test_pbo();
    logic [15:0] d;
    wr(ADDR, 16'h097D);
    @(negedge clk); pbo_clr = 1; @(negedge clk); pbo_clr = 0;
    rd(d); check("R4 override clear", d, 16'h0000);
    wr(ADDR, 16'h0100);
    @(negedge clk); pbo_clr = 1; io_addr = ADDR; io_wdata = 16'hFFFF; io_wr = 1;
    @(negedge clk); pbo_clr = 0; io_wr = 0; io_addr = 0;
    rd(d); check("R12 clear beats write", d, 16'h0000);
  endtask

  task automatic test_domains();
    logic [15:0] d;
    wr(ADDR, 16'h097D);
    @(negedge clk); core_rst_n = 0; tick(2); core_rst_n = 1; tick(4);
    rd(d); check("R5 core reset", d, 16'h0900);
    wr(ADDR, 16'h097D);
    @(negedge clk); rsm_rst_n = 0; tick(2); rsm_rst_n = 1; tick(4);
    rd(d); check("R6 resume reset", d, 16'h0100);
    wr(ADDR, 16'h097D);
    @(negedge clk); rtc_rst_n = 0; tick(2); rtc_rst_n = 1; tick(4);
    rd(d); check("R7 rtc reset", d, 16'h0000);
  endtask

  task automatic test_wake();
    wr(ADDR, 16'h0138);
    clear_status(); sleep_state = 3'd3;
    tick(2); check("R8 idle no wake", {15'h0, wake_req}, 16'h0);
    st_usb1 = 1; tick(1); check("R8 usb1 wake", {15'h0, wake_req}, 16'h1);
    st_usb1 = 0; st_usb2 = 1; tick(1); check("R8 usb2 wake", {15'h0, wake_req}, 16'h1);
    st_usb2 = 0; st_audio = 1; tick(1); check("R8 audio wake", {15'h0, wake_req}, 16'h1);
    st_audio = 0; st_ri = 1; tick(1); check("R8 ri wake", {15'h0, wake_req}, 16'h1);
    st_ri = 0; tick(1); check("R8 all clear", {15'h0, wake_req}, 16'h0);
    wr(ADDR, 16'h0000); st_usb1 = 1; tick(1);
    check("R8 disabled source", {15'h0, wake_req}, 16'h0);
    clear_status();
  endtask

  task automatic test_pme();
    wr(ADDR, 16'h0800); clear_status(); st_pme = 1;
    sleep_state = 3'd1; s5_by_override = 0; tick(1);
    check("R9 pme wake S1", {15'h0, wake_req}, 16'h1);
    sleep_state = 3'd5; tick(1);
    check("R9 pme wake S5 normal", {15'h0, wake_req}, 16'h1);
    s5_by_override = 1; tick(1);
    check("R9 pme blocked S5 override", {15'h0, wake_req}, 16'h0);
    check("R10 pme sci in S5 override", {15'h0, sci_req}, 16'h1);
    sleep_state = 3'd0; s5_by_override = 0; tick(1);
    check("R9 pme no wake S0", {15'h0, wake_req}, 16'h0);
    st_pme = 0; tick(1);
    check("R10 sci idle", {15'h0, sci_req}, 16'h0);
    wr(ADDR, 16'h0040); st_tco = 1; tick(1);
    check("R10 tco sci", {15'h0, sci_req}, 16'h1);
    wr(ADDR, 16'h0000); tick(1);
    check("R10 tco disabled", {15'h0, sci_req}, 16'h0);
    clear_status();
  endtask

  task automatic test_thermal();
    logic seen;
    thrm_pin = 0; wr(ADDR, 16'h0005); tick(3);
    @(negedge clk); thrm_pin = 1;
    @(posedge clk); #1 check("R11 no pulse after 1 edge", {15'h0, thrm_set}, 16'h0);
    @(posedge clk); #1 check("R11 pulse high polarity", {15'h0, thrm_set}, 16'h1);
    @(posedge clk); #1 check("R11 pulse one cycle", {15'h0, thrm_set}, 16'h0);
    wr(ADDR, 16'h0000); thrm_pin = 1; tick(3);
    wr(ADDR, 16'h0001); tick(3);
    @(negedge clk); thrm_pin = 0;
    @(posedge clk); @(posedge clk); #1
    check("R11 pulse low polarity", {15'h0, thrm_set}, 16'h1);
    wr(ADDR, 16'h0000); thrm_pin = 1; tick(3);
    seen = 0;
    thrm_pin = 0;
    for (int i = 0; i < 5; i++) begin @(posedge clk); #1 seen |= thrm_set; end
    check("R11 disabled no pulse", {15'h0, seen}, 16'h0);
    wr(ADDR, 16'h0001); thrm_pin = 1; tick(3);
    seen = 0;
    @(negedge clk); thrm_pin = 0; tick(1);
    io_addr = ADDR; io_wdata = 16'h0000; io_wr = 1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 seen |= thrm_set;
      io_wr = 0; io_addr = 0;
    end
    check("R11 enable cleared as pin arrives", {15'h0, seen}, 16'h0);
    thrm_pin = 1;
  endtask

  initial begin
    core_rst_n = 0; rsm_rst_n = 0; rtc_rst_n = 0; pbo_clr = 0;
    io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0;
    clear_status(); thrm_pin = 1; sleep_state = 0; s5_by_override = 0;
    tick(3);
    core_rst_n = 1; rsm_rst_n = 1; rtc_rst_n = 1;
    tick(4);
    test_reset_state();
    test_rw();
    test_pbo();
    test_domains();
    test_wake();
    test_pme();
    test_thermal();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule